// File: doc/BRIEF.md
# Gradient Orientation Binner

This block turns a signed horizontal and vertical gradient pair into one of nine unsigned-orientation bins. Each bin covers 20 degrees of the half-circle. It computes no arctangent. Both components are first folded into the first quadrant, and a flag records whether they point in opposite directions. The vertical magnitude is then compared against the horizontal magnitude scaled by four fixed tangent slopes. The comparisons form a thermometer code, which is reduced to a sector index. A small table, addressed by the sector index together with the opposite-sign flag, gives the final bin.

The block accepts one pixel per clock, and the input may be idle on any cycle. A valid flag travels with the data through three register stages. The block is meant to sit between a gradient stage and a histogram accumulator in a feature-extraction pipeline.

Top module: `grad_orient_binner`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock edges. Each accepted pixel produces exactly one output result, and results leave in the order the pixels arrived.
- R2: While `rst_n` is low, `out_valid` is 0 and `out_bin` is 0.
- R3: Orientation is atan2(gy, gx) taken modulo 180 degrees. Bin k covers 20k to 20k+20 degrees, so `out_bin` always lies in 0..8.
- R4: The sector index is the number of slopes C in {93, 215, 443, 1452} for which 256·|gy| >= C·|gx|. These slopes are tan 20/40/60/80 degrees in fixed point with 8 fraction bits. A slope counts only when |gy| is nonzero, so a value that meets a slope exactly falls in the higher sector.
- R5: When gx and gy have the same sign, or either of them is zero, the bin equals the sector index (0..4).
- R6: When gx and gy are both nonzero and of opposite sign, the bin equals 8 minus the sector index.
- R7: A zero gradient (gx = gy = 0) yields bin 0.
- R8: The most negative input code, -2048, is treated as magnitude 2048 with no overflow.
- R9: Negating both components (point reflection) does not change the bin.
- R10: Back-to-back pixels and pixels with idle gaps between them are each binned independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Gradient pair present this cycle |
| grad_x | input | 12 | Horizontal gradient, two's complement |
| grad_y | input | 12 | Vertical gradient, two's complement |
| out_valid | output | 1 | Bin result present this cycle |
| out_bin | output | 4 | Orientation bin index 0..8 |

## Verification
On every cycle the assertions check five things:
- the three-cycle valid latency;
- that the bin stays within 0..8;
- that a zero gradient always produces bin 0;
- that the comparator outputs form a monotone thermometer code;
- that the fold stage never flags opposite signs when a component is zero.

The exact bin values can only be shown by the bench's scenarios. These include the placement of each tangent boundary, the mirror mapping for opposite signs, the -2048 extreme, point-reflection symmetry, and streams with and without gaps.

// File: rtl/obin_pkg.sv
package obin_pkg;
  localparam int FRAC_W   = 8;   // fraction bits of the slope constants
  localparam int COEF_W   = 11;  // width of the largest slope constant
  localparam int NUM_TH   = 4;   // sector boundaries inside one quadrant
  localparam int SECT_W   = 3;   // holds 0..NUM_TH
  localparam int NUM_BINS = 9;
  localparam int BIN_W    = 4;

  typedef logic [BIN_W-1:0]  bin_t;
  typedef logic [SECT_W-1:0] sect_t;

  // tan(20*(k+1) deg) scaled by 2**FRAC_W, rounded
  function automatic logic [COEF_W-1:0] slope_coef(input int k);
    case (k)
      0:       return COEF_W'(93);
      1:       return COEF_W'(215);
      2:       return COEF_W'(443);
      default: return COEF_W'(1452);
    endcase
  endfunction

  function automatic sect_t therm_count(input logic [NUM_TH-1:0] t);
    sect_t c;
    c = '0;
    for (int i = 0; i < NUM_TH; i++) c = c + SECT_W'(t[i]);
    return c;
  endfunction

  function automatic bin_t fold_bin(input logic mirror, input sect_t sector);
    return mirror ? (BIN_W'(NUM_BINS - 1) - BIN_W'(sector)) : BIN_W'(sector);
  endfunction
endpackage

// File: rtl/grad_fold.sv
module grad_fold #(
  parameter int GRAD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [GRAD_W-1:0] gx,
  input  logic [GRAD_W-1:0] gy,
  output logic              f_valid,
  output logic [GRAD_W-1:0] f_ax,
  output logic [GRAD_W-1:0] f_ay,
  output logic              f_mirror
);
  logic              sx, sy, mirror_c;
  logic [GRAD_W-1:0] ax_c, ay_c;

  always_comb begin
    sx       = gx[GRAD_W-1];
    sy       = gy[GRAD_W-1];
    ax_c     = sx ? (GRAD_W'(0) - gx) : gx;
    ay_c     = sy ? (GRAD_W'(0) - gy) : gy;
    mirror_c = (sx ^ sy) && (gx != '0) && (gy != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_valid  <= 1'b0;
      f_ax     <= '0;
      f_ay     <= '0;
      f_mirror <= 1'b0;
    end else begin
      f_valid  <= in_valid;
      f_ax     <= ax_c;
      f_ay     <= ay_c;
      f_mirror <= mirror_c;
    end
  end

  // R7
  zero_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gx == '0 && gy == '0) |=> (f_ax == '0 && f_ay == '0 && !f_mirror));

  // R6
  mirror_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gx == '0 || gy == '0) |=> !f_mirror);
endmodule

// File: rtl/sector_compare.sv
module sector_compare
  import obin_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  input  logic [MAG_W-1:0] f_ax,
  input  logic [MAG_W-1:0] f_ay,
  input  logic             f_mirror,
  output logic             s_valid,
  output sect_t            s_sector,
  output logic             s_mirror
);
  localparam int PROD_W = MAG_W + COEF_W;

  logic [NUM_TH-1:0] therm;
  logic [PROD_W-1:0] lhs;

  assign lhs = PROD_W'({f_ay, {FRAC_W{1'b0}}});

  for (genvar k = 0; k < NUM_TH; k++) begin : g_slope
    localparam logic [COEF_W-1:0] SLOPE = slope_coef(k);
    logic [PROD_W-1:0] rhs;
    assign rhs      = PROD_W'(f_ax) * PROD_W'(SLOPE);
    assign therm[k] = (f_ay != '0) && (lhs >= rhs);

    if (k > 0) begin : g_mono
      // R4
      therm_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> (!therm[k] || therm[k-1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_sector <= '0;
      s_mirror <= 1'b0;
    end else begin
      s_valid  <= f_valid;
      s_sector <= therm_count(therm);
      s_mirror <= f_mirror;
    end
  end
endmodule

// File: rtl/bin_lookup.sv
module bin_lookup
  import obin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  input  sect_t s_sector,
  input  logic  s_mirror,
  output logic  o_valid,
  output bin_t  o_bin
);
  localparam int ADDR_W = SECT_W + 1;
  localparam int LUT_D  = 1 << ADDR_W;

  bin_t              lut [LUT_D];
  logic [ADDR_W-1:0] addr;

  assign addr = {s_mirror, s_sector};

  always_comb begin
    for (int a = 0; a < LUT_D; a++) begin
      logic [ADDR_W-1:0] ai;
      ai     = ADDR_W'(a);
      lut[a] = (ai[SECT_W-1:0] <= SECT_W'(NUM_TH))
             ? fold_bin(ai[ADDR_W-1], ai[SECT_W-1:0]) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_bin   <= '0;
    end else begin
      o_valid <= s_valid;
      o_bin   <= lut[addr];
    end
  end
endmodule

// File: rtl/grad_orient_binner.sv
module grad_orient_binner
  import obin_pkg::*;
#(
  parameter int GRAD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [GRAD_W-1:0] grad_x,
  input  logic [GRAD_W-1:0] grad_y,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_bin
);
  localparam int LATENCY = 3;

  logic              f_valid, f_mirror, s_valid, s_mirror;
  logic [GRAD_W-1:0] f_ax, f_ay;
  sect_t             s_sector;

  grad_fold #(.GRAD_W(GRAD_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gx(grad_x), .gy(grad_y),
    .f_valid(f_valid), .f_ax(f_ax), .f_ay(f_ay), .f_mirror(f_mirror)
  );

  sector_compare #(.MAG_W(GRAD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_ax(f_ax), .f_ay(f_ay),
    .f_mirror(f_mirror), .s_valid(s_valid), .s_sector(s_sector), .s_mirror(s_mirror)
  );

  bin_lookup u_lut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sector(s_sector),
    .s_mirror(s_mirror), .o_valid(out_valid), .o_bin(out_bin)
  );

  // edges seen since reset release, saturating; guards the $past checks
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   warm <= '0;
    else if (warm != 2'(LATENCY)) warm <= warm + 2'd1;
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'(LATENCY)) |-> (out_valid == $past(in_valid, 3)));

  // R3
  bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bin <= BIN_W'(NUM_BINS - 1)));

  // R7
  zero_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'(LATENCY)) && $past(in_valid && grad_x == '0 && grad_y == '0, 3))
      |-> (out_bin == '0));
endmodule

// File: tb/test_grad_orient_binner.sv
`timescale 1ns/1ps
module test_grad_orient_binner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] grad_x = '0, grad_y = '0;
  logic        out_valid;
  logic [3:0]  out_bin;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  grad_orient_binner i_grad_orient_binner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grad_x(grad_x),
    .grad_y(grad_y), .out_valid(out_valid), .out_bin(out_bin)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // restated from R4..R7
  function automatic int model_bin(input logic signed [11:0] gx, input logic signed [11:0] gy);
    int ax, ay, s;
    int c[4] = '{93, 215, 443, 1452};
    ax = (gx < 0) ? -int'(gx) : int'(gx);
    ay = (gy < 0) ? -int'(gy) : int'(gy);
    s = 0;
    if (ay != 0) foreach (c[k]) if (256 * ay >= c[k] * ax) s++;
    if (gx != 0 && gy != 0 && ((gx < 0) != (gy < 0))) return 8 - s;
    return s;
  endfunction

  task automatic apply(input int gx, input int gy, input int exp, input string tag);
    grad_x = 12'(gx); grad_y = 12'(gy); in_valid = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    idle(5);
    chk(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected valid", 1, 0);
      else begin
        int e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(int'(out_bin) == e, t, int'(out_bin), e);
      end
    end
  end

  task automatic t_reset();
    in_valid = 1'b1; grad_x = 12'd100; grad_y = 12'd100;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 valid in reset", int'(out_valid), 0);
      chk(out_bin == '0, "R2 bin in reset", int'(out_bin), 0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_latency();
    grad_x = 12'd30; grad_y = 12'd100; in_valid = 1'b1;
    exp_q.push_back(3); tag_q.push_back("R1 latency bin");
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R1 edge1", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 edge2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1 edge3", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 edge4", int'(out_valid), 0);
    drain();
  endtask

  task automatic t_axes();
    apply(100, 0, 0, "R5 +x axis");
    apply(-100, 0, 0, "R5 -x axis");
    apply(0, 100, 4, "R5 +y axis");
    apply(0, -100, 4, "R5 -y axis");
    apply(0, 0, 0, "R7 zero gradient");
    drain();
  endtask

  task automatic t_quadrants();
    apply(100, 100, 2, "R5 45deg");
    apply(-100, -100, 2, "R9 225deg");
    apply(-100, 100, 6, "R6 135deg");
    apply(100, -100, 6, "R6 315deg");
    apply(100, 30, 0, "R5 17deg");
    apply(100, -30, 8, "R6 343deg");
    apply(30, 100, 3, "R5 73deg");
    apply(-30, 100, 5, "R6 107deg");
    drain();
  endtask

  task automatic t_thresholds();
    apply(256, 92, 0, "R4 below tan20");
    apply(256, 93, 1, "R4 at tan20");
    apply(256, 214, 1, "R4 below tan40");
    apply(256, 215, 2, "R4 at tan40");
    apply(256, 442, 2, "R4 below tan60");
    apply(256, 443, 3, "R4 at tan60");
    apply(256, 1451, 3, "R4 below tan80");
    apply(256, 1452, 4, "R4 at tan80");
    apply(-256, 93, 7, "R6 mirrored tan20");
    drain();
  endtask

  task automatic t_extremes();
    apply(-2048, -2048, 2, "R8 both min");
    apply(-2048, 0, 0, "R8 min x");
    apply(0, -2048, 4, "R8 min y");
    apply(-2048, 1, 8, "R8 min x tiny y");
    apply(2047, -2048, 6, "R8 max x min y");
    apply(-2048, 2047, 6, "R8 min x max y");
    drain();
  endtask

  task automatic t_stream();
    logic [31:0] lf = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      int gx, gy;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      gx = int'($signed(lf[11:0])); gy = int'($signed(lf[23:12]));
      if (lf[24]) begin gx = gx / 64; gy = gy / 64; end
      if (gx == -2048 || gy == -2048) gx = 1;
      if (lf[25]) begin
        apply(gx, gy, model_bin(12'(gx), 12'(gy)), "R10 stream");
        apply(-gx, -gy, model_bin(12'(gx), 12'(gy)), "R9 reflected");
      end else begin
        apply(gx, gy, model_bin(12'(gx), 12'(gy)), "R10 stream");
      end
      if (lf[27:26] == 2'b00) idle(int'(lf[29:28]) + 1);
    end
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_axes();
    t_quadrants();
    t_thresholds();
    t_extremes();
    t_stream();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule